// File: doc/BRIEF.md
# Page Program Collector with In-Page Wraparound

This block gathers the data bytes of one page-program transaction into a local page buffer and then commits them to a byte-wide memory array. A start strobe carries the target address. Its upper bits pick the page, and its low bits pick the column where the first byte lands. Each accepted data byte goes to the current column, and the column then advances. The column wraps from the last column back to column zero of the same page and never spills into the next page. If more bytes arrive than a page holds, later bytes overwrite earlier ones, so the last page-worth of bytes is what gets kept.

A per-column "touched" map records which buffer entries hold new data. When the host signals a valid end, the block walks every column of the page in ascending order, one per clock. For each touched column it reads the old array byte and writes back the AND of the old byte and the buffered byte, since programming can only clear bits. Columns that were never sent are not written at all. Done is pulsed once, in the same cycle as the slot of the last column.

An abort strobe, or a valid end with no data bytes, drops the transaction without any array write. The host decides whether a transaction ended on a byte boundary and signals either the valid end or the abort. Opcode decoding, protection checks and program timing are left to neighbouring logic.

Top module: `pgm_page_collector`

## Requirements
- R1: While reset is high and on the cycle after it, the write enable and done are low.
- R2: A start strobe takes the page from address bits [ADDR_W-1:COL_W] and the first column from bits [COL_W-1:0]. The k-th accepted byte (k counting from 0) is destined for column (start column + k) modulo the page size, in the selected page.
- R3: The column wraps from the last column to column 0 of the same page, and every write address carries the page given at start.
- R4: When more bytes than the page size are sent, each column keeps the last byte sent to it, so only the last page-worth of bytes is committed.
- R5: Only columns that received a byte in the current transaction are written. All other array bytes keep their prior contents.
- R6: The array is read at arr_rd_addr_o and returns data one cycle later on arr_rdata_i. The value written is that old byte ANDed with the buffered byte.
- R7: A valid end with no accepted data byte produces no array write and no done pulse.
- R8: Abort during collection returns the block to idle with no write and no done. Bytes sent before the abort are not committed by any later transaction.
- R9: The commit visits columns in ascending order, one per clock. Done is high for exactly one cycle per committed transaction.
- R10: Start, data, end and abort strobes are ignored while a commit is running, and data and end strobes are ignored while the block is idle. Within collection the priority is start, then abort, then end, then data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transaction at start_addr_i |
| start_addr_i | input | ADDR_W | Page (upper bits) and first column (low COL_W bits) |
| byte_vld_i | input | 1 | byte_i holds one data byte this cycle |
| byte_i | input | 8 | Data byte |
| end_ok_i | input | 1 | Transaction ended validly; commit |
| abort_i | input | 1 | Transaction rejected; drop all bytes |
| arr_rd_addr_o | output | ADDR_W | Array read address (data returns next cycle) |
| arr_rdata_i | input | 8 | Array read data |
| arr_wr_addr_o | output | ADDR_W | Array write address |
| arr_wr_data_o | output | 8 | Array write data (old AND new) |
| arr_wr_en_o | output | 1 | Array write enable |
| done_o | output | 1 | One-cycle pulse at the end of a commit |

## Verification
The hardest case to reach is a column that is overwritten after the wrap. Once more bytes than a page holds have been sent, the buffer holds a mix in which some columns carry their second byte and others only their first, while the touched map is fully set. The bench reaches this case with a sweep over a 16-byte page. It covers every start column and every byte count from 1 to 20, and it loads each target page with a fresh pattern first, so that the AND with old data stays visible. Commits that overlap incoming strobes are reached by driving start and data strobes during the walk. A byte stream that is aborted and then partially resent checks that the aborted columns stay unwritten.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef enum logic [1:0] {
    PG_IDLE    = 2'd0,
    PG_COLLECT = 2'd1,
    PG_WALK    = 2'd2
  } pg_state_t;
endpackage

// File: rtl/pgm_ctrl.sv
module pgm_ctrl
  import pgm_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int COL_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [ADDR_W-1:0]         start_addr_i,
  input  logic                      byte_vld_i,
  input  logic                      end_ok_i,
  input  logic                      abort_i,
  input  logic                      any_byte_i,
  output pg_state_t                 state_o,
  output logic [ADDR_W-COL_W-1:0]   page_o,
  output logic [COL_W-1:0]          start_col_o,
  output logic                      load_o,
  output logic                      clear_o,
  output logic                      take_o,
  output logic                      issue_o,
  output logic [COL_W-1:0]          walk_col_o
);
  localparam int PG_W = ADDR_W - COL_W;

  pg_state_t         state_q, state_d;
  logic [PG_W-1:0]   page_q;
  logic [COL_W-1:0]  walk_q;
  logic              in_collect, in_walk;
  logic              start_acc, abort_acc, end_acc, take_acc, walk_last;

  always_comb begin
    in_collect = (state_q == PG_COLLECT);
    in_walk    = (state_q == PG_WALK);
    start_acc  = start_i && !in_walk;
    abort_acc  = in_collect && !start_i && abort_i;
    end_acc    = in_collect && !start_i && !abort_i && end_ok_i;
    take_acc   = in_collect && !start_i && !abort_i && !end_ok_i && byte_vld_i;
    walk_last  = in_walk && (walk_q == {COL_W{1'b1}});
  end

  always_comb begin
    state_d = state_q;
    if (start_acc)      state_d = PG_COLLECT;
    else if (abort_acc) state_d = PG_IDLE;
    else if (end_acc)   state_d = any_byte_i ? PG_WALK : PG_IDLE;
    else if (walk_last) state_d = PG_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PG_IDLE;
      page_q  <= '0;
      walk_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start_acc) page_q <= start_addr_i[ADDR_W-1:COL_W];
      if (in_walk) walk_q <= walk_q + 1'b1;
      else         walk_q <= '0;
    end
  end

  assign state_o     = state_q;
  assign page_o      = page_q;
  assign start_col_o = start_addr_i[COL_W-1:0];
  assign load_o      = start_acc;
  assign clear_o     = start_acc || abort_acc;
  assign take_o      = take_acc;
  assign issue_o     = in_walk;
  assign walk_col_o  = walk_q;
endmodule

// File: rtl/pgm_col_track.sv
module pgm_col_track #(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic                  clear_i,
  input  logic                  take_i,
  output logic [COL_W-1:0]      col_o,
  output logic [(1<<COL_W)-1:0] touched_o,
  output logic                  any_o
);
  localparam int PAGE = 1 << COL_W;

  logic [COL_W-1:0] col_q;
  logic             any_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      any_q <= 1'b0;
    end else begin
      if (load_i)      col_q <= start_col_i;
      else if (take_i) col_q <= col_q + 1'b1;
      if (clear_i)     any_q <= 1'b0;
      else if (take_i) any_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE; g++) begin : g_mark
    always_ff @(posedge clk) begin
      if (rst || clear_i)
        touched_o[g] <= 1'b0;
      else if (take_i && (col_q == COL_W'(g)))
        touched_o[g] <= 1'b1;
    end
  end

  assign col_o = col_q;
  assign any_o = any_q;
endmodule

// File: rtl/pgm_page_ram.sv
module pgm_page_ram #(
  parameter int COL_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [COL_W-1:0]  wcol_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [COL_W-1:0]  rcol_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAGE = 1 << COL_W;

  logic [DATA_W-1:0] mem [PAGE];

  always_ff @(posedge clk) begin
    if (we_i) mem[wcol_i] <= wdata_i;
    rdata_o <= mem[rcol_i];
  end
endmodule

// File: rtl/pgm_rmw_stage.sv
module pgm_rmw_stage #(
  parameter int ADDR_W = 24,
  parameter int COL_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    issue_i,
  input  logic [COL_W-1:0]        issue_col_i,
  input  logic [ADDR_W-COL_W-1:0] issue_page_i,
  input  logic                    issue_touch_i,
  input  logic [DATA_W-1:0]       buf_q_i,
  input  logic [DATA_W-1:0]       arr_rdata_i,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [DATA_W-1:0]       wr_data_o,
  output logic                    wr_en_o,
  output logic                    done_o
);
  localparam int PG_W = ADDR_W - COL_W;

  logic              s1_v, s1_touch;
  logic [COL_W-1:0]  s1_col;
  logic [PG_W-1:0]   s1_page;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s1_touch  <= 1'b0;
      s1_col    <= '0;
      s1_page   <= '0;
      wr_en_o   <= 1'b0;
      done_o    <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      s1_v     <= issue_i;
      s1_touch <= issue_i && issue_touch_i;
      s1_col   <= issue_col_i;
      s1_page  <= issue_page_i;
      wr_en_o  <= s1_v && s1_touch;
      done_o   <= s1_v && (s1_col == {COL_W{1'b1}});
      if (s1_v) begin
        wr_addr_o <= {s1_page, s1_col};
        wr_data_o <= buf_q_i & arr_rdata_i;
      end
    end
  end
endmodule

// File: rtl/pgm_page_collector.sv
module pgm_page_collector
  import pgm_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              end_ok_i,
  input  logic              abort_i,
  output logic [ADDR_W-1:0] arr_rd_addr_o,
  input  logic [7:0]        arr_rdata_i,
  output logic [ADDR_W-1:0] arr_wr_addr_o,
  output logic [7:0]        arr_wr_data_o,
  output logic              arr_wr_en_o,
  output logic              done_o
);
  localparam int PG_W = ADDR_W - COL_W;
  localparam int PAGE = 1 << COL_W;

  pg_state_t         ctl_state;
  logic [PG_W-1:0]   page;
  logic [COL_W-1:0]  start_col, cur_col, walk_col;
  logic              load, clear, take, issue, any_byte;
  logic [PAGE-1:0]   touched;
  logic [7:0]        buf_q;

  pgm_ctrl #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .start_i(start_i), .start_addr_i(start_addr_i),
    .byte_vld_i(byte_vld_i), .end_ok_i(end_ok_i), .abort_i(abort_i),
    .any_byte_i(any_byte),
    .state_o(ctl_state), .page_o(page), .start_col_o(start_col),
    .load_o(load), .clear_o(clear), .take_o(take),
    .issue_o(issue), .walk_col_o(walk_col)
  );

  pgm_col_track #(.COL_W(COL_W)) u_track (
    .clk(clk), .rst(rst),
    .load_i(load), .start_col_i(start_col),
    .clear_i(clear), .take_i(take),
    .col_o(cur_col), .touched_o(touched), .any_o(any_byte)
  );

  pgm_page_ram #(.COL_W(COL_W), .DATA_W(8)) u_buf (
    .clk(clk),
    .we_i(take), .wcol_i(cur_col), .wdata_i(byte_i),
    .rcol_i(walk_col), .rdata_o(buf_q)
  );

  pgm_rmw_stage #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(8)) u_rmw (
    .clk(clk), .rst(rst),
    .issue_i(issue), .issue_col_i(walk_col), .issue_page_i(page),
    .issue_touch_i(touched[walk_col]),
    .buf_q_i(buf_q), .arr_rdata_i(arr_rdata_i),
    .wr_addr_o(arr_wr_addr_o), .wr_data_o(arr_wr_data_o),
    .wr_en_o(arr_wr_en_o), .done_o(done_o)
  );

  assign arr_rd_addr_o = {page, walk_col};
endmodule

// File: rtl/pgm_page_collector_chk.sv
module pgm_page_collector_chk
  import pgm_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int COL_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              abort_i,
  input logic [7:0]        arr_rdata_i,
  input logic [ADDR_W-1:0] arr_wr_addr_o,
  input logic [7:0]        arr_wr_data_o,
  input logic              arr_wr_en_o,
  input logic              done_o,
  input pg_state_t         state_i
);
  // R1: outputs quiet after a reset cycle
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!arr_wr_en_o && !done_o));

  // R6: a write may only clear bits of the byte read one stage earlier
  p_clear_only_r6: assert property (@(posedge clk) disable iff (rst)
    arr_wr_en_o |-> ((arr_wr_data_o & ~$past(arr_rdata_i)) == 8'h00));

  // R9: back-to-back writes go to ascending adjacent columns
  p_ascend_r9: assert property (@(posedge clk) disable iff (rst)
    (arr_wr_en_o && $past(arr_wr_en_o)) |-> (arr_wr_addr_o == $past(arr_wr_addr_o) + 1'b1));

  // R9: done is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: abort in collection returns to idle
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (state_i == PG_COLLECT && abort_i && !start_i) |=> (state_i == PG_IDLE));

  // R10: start during a commit does not open a new collection
  p_walk_ignores_r10: assert property (@(posedge clk) disable iff (rst)
    (state_i == PG_WALK && start_i) |=> (state_i != PG_COLLECT));
endmodule

bind pgm_page_collector pgm_page_collector_chk #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i),
  .arr_rdata_i(arr_rdata_i), .arr_wr_addr_o(arr_wr_addr_o),
  .arr_wr_data_o(arr_wr_data_o), .arr_wr_en_o(arr_wr_en_o),
  .done_o(done_o), .state_i(ctl_state)
);

// File: tb/pgm_page_collector_bench.sv
module pgm_page_collector_bench;
  localparam int AW  = 8;
  localparam int CW  = 4;
  localparam int PG  = 1 << CW;
  localparam int NPG = 1 << (AW - CW);
  localparam int MEM = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, start, byte_vld, end_ok, abort;
  logic [AW-1:0] start_addr, rd_addr, wr_addr;
  logic [7:0]    data_in, rdata, wr_data;
  logic          wr_en, done;

  pgm_page_collector #(.ADDR_W(AW), .COL_W(CW)) u_pgm_page_collector (
    .clk(clk), .rst(rst), .start_i(start), .start_addr_i(start_addr),
    .byte_vld_i(byte_vld), .byte_i(data_in), .end_ok_i(end_ok), .abort_i(abort),
    .arr_rd_addr_o(rd_addr), .arr_rdata_i(rdata),
    .arr_wr_addr_o(wr_addr), .arr_wr_data_o(wr_data),
    .arr_wr_en_o(wr_en), .done_o(done)
  );

  // array stub: one-cycle read latency, plus a bench preload path
  logic [7:0]    arr [MEM];
  logic          ld_en;
  logic [AW-1:0] ld_addr;
  logic [7:0]    ld_data;
  always_ff @(posedge clk) begin
    rdata <= arr[rd_addr];
    if (wr_en)      arr[wr_addr] <= wr_data;
    else if (ld_en) arr[ld_addr] <= ld_data;
  end

  logic [7:0] exp_mem [MEM];
  logic [7:0] ref_buf [PG];
  bit         ref_touch [PG];
  int         ref_col;

  int checks = 0, fails = 0;
  int wr_cnt, done_cnt, last_col, cur_page;
  bit bad_page, bad_order, finished = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        wr_cnt++;
        if (int'(wr_addr[AW-1:CW]) != cur_page) bad_page = 1'b1;
        if (int'(wr_addr[CW-1:0]) <= last_col) bad_order = 1'b1;
        last_col = int'(wr_addr[CW-1:0]);
      end
      if (done) done_cnt++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [7:0] pre_pat(int p, int c, int seed);
    return 8'((p * 37 + c * 11 + seed * 5) ^ 8'hA5);
  endfunction

  function automatic logic [7:0] dat_pat(int k, int s, int seed);
    return 8'(~(k * 29 + s * 3 + seed * 7 + 1));
  endfunction

  task automatic clear_mon(int page);
    wr_cnt = 0; done_cnt = 0; bad_page = 1'b0; bad_order = 1'b0;
    last_col = -1; cur_page = page;
  endtask

  task automatic preload(int p, int seed);
    for (int c = 0; c < PG; c++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = AW'(p * PG + c); ld_data = pre_pat(p, c, seed);
      exp_mem[p * PG + c] = pre_pat(p, c, seed);
    end
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic do_start(int p, int s);
    @(negedge clk); start = 1'b1; start_addr = AW'(p * PG + s);
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < PG; c++) ref_touch[c] = 1'b0;
    ref_col = s;
  endtask

  task automatic do_byte(logic [7:0] d);
    @(negedge clk); byte_vld = 1'b1; data_in = d;
    @(negedge clk); byte_vld = 1'b0;
    ref_buf[ref_col] = d; ref_touch[ref_col] = 1'b1;
    ref_col = (ref_col + 1) % PG;
  endtask

  task automatic pulse_end();
    @(negedge clk); end_ok = 1'b1;
    @(negedge clk); end_ok = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask

  task automatic settle();
    repeat (PG + 12) @(negedge clk);
  endtask

  task automatic commit_ref(int p);
    for (int c = 0; c < PG; c++)
      if (ref_touch[c]) exp_mem[p * PG + c] = exp_mem[p * PG + c] & ref_buf[c];
  endtask

  function automatic int ref_pop();
    int n = 0;
    for (int c = 0; c < PG; c++) n += int'(ref_touch[c]);
    return n;
  endfunction

  task automatic check_array(string req, string what);
    int mism = 0;
    for (int a = 0; a < MEM; a++) if (arr[a] !== exp_mem[a]) mism++;
    check(mism == 0, req, what, mism, 0);
  endtask

  task automatic run_program(int p, int s, int n, int seed);
    string req;
    preload(p, seed);
    clear_mon(p);
    do_start(p, s);
    for (int k = 0; k < n; k++) do_byte(dat_pat(k, s, seed));
    pulse_end();
    settle();
    commit_ref(p);
    req = (n > PG) ? "R4" : ((s + n > PG) ? "R3" : "R2");
    check_array(req, "array contents after commit (R6 and-merge)");
    check(wr_cnt == ref_pop(), "R5", "write count equals touched columns", wr_cnt, ref_pop());
    check(done_cnt == 1, "R9", "done pulse count", done_cnt, 1);
    check(!bad_order, "R9", "ascending column order", int'(bad_order), 0);
    check(!bad_page, "R3", "writes stay in start page", int'(bad_page), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1'b1; start = 1'b0; byte_vld = 1'b0; end_ok = 1'b0; abort = 1'b0;
    start_addr = '0; data_in = '0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    check(wr_en == 1'b0, "R1", "write enable in reset", int'(wr_en), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check(wr_en == 1'b0 && done == 1'b0, "R1", "quiet after reset", int'({wr_en, done}), 0);

    for (int p = 0; p < NPG; p++) preload(p, 0);

    // R6 directed: 0x0F old AND 0xF3 new -> 0x03
    @(negedge clk); ld_en = 1'b1; ld_addr = AW'(3 * PG + 5); ld_data = 8'h0F;
    exp_mem[3 * PG + 5] = 8'h0F;
    @(negedge clk); ld_en = 1'b0;
    clear_mon(3);
    do_start(3, 5); do_byte(8'hF3); pulse_end(); settle(); commit_ref(3);
    check(arr[3 * PG + 5] == 8'h03, "R6", "and-merge value", int'(arr[3 * PG + 5]), 3);
    check(wr_cnt == 1, "R6", "single write", wr_cnt, 1);

    // R7: valid end with no data bytes
    clear_mon(2);
    do_start(2, 7); pulse_end(); settle();
    check(wr_cnt == 0, "R7", "writes on empty end", wr_cnt, 0);
    check(done_cnt == 0, "R7", "done on empty end", done_cnt, 0);
    check_array("R7", "array unchanged on empty end");

    // R8: abort then a shorter resend on the same page
    clear_mon(6);
    do_start(6, 2);
    for (int k = 0; k < 5; k++) do_byte(8'h00);
    pulse_abort(); settle();
    check(wr_cnt == 0, "R8", "writes after abort", wr_cnt, 0);
    check(done_cnt == 0, "R8", "done after abort", done_cnt, 0);
    check_array("R8", "array unchanged after abort");
    clear_mon(6);
    do_start(6, 2); do_byte(8'h5A); do_byte(8'hC3); pulse_end(); settle(); commit_ref(6);
    check(wr_cnt == 2, "R8", "aborted columns not committed later", wr_cnt, 2);
    check_array("R8", "array after resend");

    // R10: data and end while idle are ignored
    clear_mon(0);
    do_byte(8'h00); ref_touch[0] = 1'b0;
    pulse_end(); settle();
    check(wr_cnt == 0 && done_cnt == 0, "R10", "idle strobes ignored", wr_cnt + done_cnt, 0);

    // R10: strobes during a commit are ignored
    clear_mon(9);
    do_start(9, 14); do_byte(8'h77); do_byte(8'h3C); do_byte(8'hE1);
    @(negedge clk); end_ok = 1'b1;
    @(negedge clk); end_ok = 1'b0; start = 1'b1; start_addr = AW'(1 * PG + 3);
    byte_vld = 1'b1; data_in = 8'h00;
    repeat (4) @(negedge clk);
    start = 1'b0; byte_vld = 1'b0; abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    settle(); commit_ref(9);
    check(wr_cnt == 3, "R10", "writes with strobes during commit", wr_cnt, 3);
    check(done_cnt == 1, "R10", "one commit only", done_cnt, 1);
    check_array("R10", "array after commit with interfering strobes");

    // sweep: every start column, 1..20 bytes, rotating pages
    for (int s = 0; s < PG; s++)
      for (int n = 1; n <= PG + 4; n++)
        run_program((s + n) % NPG, s, n, s * 31 + n);

    summary();
  end
endmodule